// File: doc/BRIEF.md
# Base-Bound Address Relocation Unit

This block stands between a processor's address-generation stage and a memory port whose read latency is fixed. Every program addresses memory from zero upward. The unit maps each of these logical addresses onto one contiguous physical window by adding a base register. In the same clock cycle it compares the untranslated logical address with a bound register, which holds the size of the window in words. The two operations run side by side, so the protection check adds no cycle to the access path.

Reads go to memory speculatively, whether or not they pass the check. A failing read raises a fault flag in its issue cycle. A small tag pipeline, as deep as the memory latency, travels alongside each outstanding read. When data returns for a faulted read, the tag pipeline masks it, so it never appears as valid read data. A failing write is never issued. Base and bound change only through a privileged load port. A new value applies to references accepted after the load, and references already in flight are not affected.

Top module: `reloc_guard`

## Requirements
- R1: While reset is asserted and directly after it, `mem_req_o`, `fault_o` and `rd_valid_o` are low, and base and bound are both zero, so any reference made before configuration faults.
- R2: A reference accepted on a clock edge (`ref_valid_i` high) appears on the memory port in the following cycle. The physical address is (base + logical address) modulo 2^PADDR_W, and the write data is passed through unchanged.
- R3: A reference faults exactly when its logical address is greater than or equal to bound. `fault_o` is high for one cycle, in the cycle after acceptance, and is low in every other cycle.
- R4: A faulting write is never issued: `mem_req_o` stays low in its issue cycle, and the memory contents at its physical address are unchanged.
- R5: A faulting read is still issued to memory (`mem_req_o` high and `mem_we_o` low) in the same cycle that `fault_o` is high.
- R6: For a non-faulting read issued in cycle c, `rd_valid_o` is high in cycle c+MEM_LAT, and `rd_data_o` equals `mem_rdata_i` in that cycle.
- R7: Data returning for a faulted read does not raise `rd_valid_o`. Whenever `rd_valid_o` is low, `rd_data_o` is zero.
- R8: Writes never cause `rd_valid_o` to rise.
- R9: `cfg_sel_i` = 0 loads base and `cfg_sel_i` = 1 loads bound from `cfg_value_i` while `cfg_load_i` is high. A reference accepted on the same edge as a load uses the old values. References accepted on later edges use the new values.
- R10: Changing base or bound does not alter the outcome of reads already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Privileged register load strobe |
| cfg_sel_i | input | 1 | 0 selects base, 1 selects bound |
| cfg_value_i | input | PADDR_W | Value to load |
| ref_valid_i | input | 1 | A reference is presented this cycle |
| ref_write_i | input | 1 | 1 for write, 0 for read |
| ref_laddr_i | input | LADDR_W | Logical word address |
| ref_wdata_i | input | DATA_W | Write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_paddr_o | output | PADDR_W | Relocated physical address |
| mem_wdata_o | output | DATA_W | Write data to memory |
| mem_rdata_i | input | DATA_W | Read data, MEM_LAT cycles after the request |
| rd_valid_o | output | 1 | Returning read data is valid and permitted |
| rd_data_o | output | DATA_W | Read data, zero when not valid |
| fault_o | output | 1 | Bound violation of the reference issued this cycle |

## Verification
Two pairs of events can fall in the same cycle. A register load can land on the edge that accepts a reference. A new reference can also issue while an earlier read is still returning, or while a load changes the bound under reads in flight. The bench provokes the first case by putting a bound load and a base load on the same edge as a read, then repeating that read on the next edge. The first read is judged against the old value and the repeat against the new one. It provokes the second case by sweeping every logical address back to back under several base and bound pairs, including a base that makes the address wrap, and by clearing the bound while reads are in flight. Each output is compared every cycle with a schedule computed arithmetically in the bench.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef enum logic {
    CFG_BASE  = 1'b0,
    CFG_BOUND = 1'b1
  } cfg_sel_e;

  // travels with each issued reference until its read data returns
  typedef struct packed {
    logic rd;   // a read was issued
    logic flt;  // it violated the bound
  } rd_tag_t;
endpackage

// File: rtl/reloc_cfg_regs.sv
module reloc_cfg_regs
  import reloc_pkg::*;
#(
  parameter int unsigned PADDR_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  cfg_sel_e           sel_i,
  input  logic [PADDR_W-1:0] value_i,
  output logic [PADDR_W-1:0] base_o,
  output logic [PADDR_W-1:0] bound_o
);
  logic [PADDR_W-1:0] base_q, base_d;
  logic [PADDR_W-1:0] bound_q, bound_d;
  logic               base_en, bound_en;

  always_comb begin
    base_en  = load_i && (sel_i == CFG_BASE);
    bound_en = load_i && (sel_i == CFG_BOUND);
    base_d   = value_i;
    bound_d  = value_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      bound_q <= '0;
    end else begin
      if (base_en)  base_q  <= base_d;
      if (bound_en) bound_q <= bound_d;
    end
  end

  assign base_o  = base_q;
  assign bound_o = bound_q;
endmodule

// File: rtl/reloc_issue.sv
module reloc_issue
  import reloc_pkg::*;
#(
  parameter int unsigned LADDR_W = 8,
  parameter int unsigned PADDR_W = 10,
  parameter int unsigned DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_valid_i,
  input  logic               ref_write_i,
  input  logic [LADDR_W-1:0] ref_laddr_i,
  input  logic [DATA_W-1:0]  ref_wdata_i,
  input  logic [PADDR_W-1:0] base_i,
  input  logic [PADDR_W-1:0] bound_i,
  output logic               req_o,
  output logic               we_o,
  output logic [PADDR_W-1:0] paddr_o,
  output logic [DATA_W-1:0]  wdata_o,
  output logic               fault_o,
  output rd_tag_t            tag_o
);
  localparam int unsigned EXT_W = PADDR_W - LADDR_W;

  logic [PADDR_W-1:0] laddr_ext;
  logic [PADDR_W-1:0] paddr_d;
  logic               viol;
  logic               req_d, fault_d, data_en;
  rd_tag_t            tag_d;

  logic               req_q, we_q, fault_q;
  logic [PADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0]  wdata_q;
  rd_tag_t            tag_q;

  // relocation and bound compare side by side in one cycle
  always_comb begin
    laddr_ext = {{EXT_W{1'b0}}, ref_laddr_i};
    paddr_d   = base_i + laddr_ext;
    viol      = (laddr_ext >= bound_i);
    // reads go out speculatively; only writes wait for the check
    req_d     = ref_valid_i && (!ref_write_i || !viol);
    fault_d   = ref_valid_i && viol;
    tag_d.rd  = ref_valid_i && !ref_write_i;
    tag_d.flt = viol;
    data_en   = ref_valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      fault_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      req_q   <= req_d;
      fault_q <= fault_d;
      tag_q   <= tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      paddr_q <= '0;
      wdata_q <= '0;
    end else if (data_en) begin
      we_q    <= ref_write_i;
      paddr_q <= paddr_d;
      wdata_q <= ref_wdata_i;
    end
  end

  assign req_o   = req_q;
  assign we_o    = we_q && req_q;
  assign paddr_o = paddr_q;
  assign wdata_o = wdata_q;
  assign fault_o = fault_q;
  assign tag_o   = tag_q;
endmodule

// File: rtl/reloc_tag_pipe.sv
module reloc_tag_pipe
  import reloc_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  rd_tag_t tag_i,
  output logic    rd_valid_o
);
  rd_tag_t [DEPTH-1:0] pipe_q;
  rd_tag_t [DEPTH-1:0] pipe_d;

  generate
    if (DEPTH == 1) begin : g_single
      always_comb pipe_d[0] = tag_i;
    end else begin : g_shift
      always_comb pipe_d = {pipe_q[DEPTH-2:0], tag_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rd_valid_o = pipe_q[DEPTH-1].rd && !pipe_q[DEPTH-1].flt;
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
  import reloc_pkg::*;
#(
  parameter int unsigned LADDR_W = 8,
  parameter int unsigned PADDR_W = 10,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned MEM_LAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load_i,
  input  logic               cfg_sel_i,
  input  logic [PADDR_W-1:0] cfg_value_i,
  input  logic               ref_valid_i,
  input  logic               ref_write_i,
  input  logic [LADDR_W-1:0] ref_laddr_i,
  input  logic [DATA_W-1:0]  ref_wdata_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [PADDR_W-1:0] mem_paddr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               rd_valid_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               fault_o
);
  logic [PADDR_W-1:0] base_w, bound_w;
  rd_tag_t            tag_w;
  logic               rd_ok;

  reloc_cfg_regs #(.PADDR_W(PADDR_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (cfg_load_i),
    .sel_i   (cfg_sel_e'(cfg_sel_i)),
    .value_i (cfg_value_i),
    .base_o  (base_w),
    .bound_o (bound_w)
  );

  reloc_issue #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W), .DATA_W(DATA_W)) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_valid_i (ref_valid_i),
    .ref_write_i (ref_write_i),
    .ref_laddr_i (ref_laddr_i),
    .ref_wdata_i (ref_wdata_i),
    .base_i      (base_w),
    .bound_i     (bound_w),
    .req_o       (mem_req_o),
    .we_o        (mem_we_o),
    .paddr_o     (mem_paddr_o),
    .wdata_o     (mem_wdata_o),
    .fault_o     (fault_o),
    .tag_o       (tag_w)
  );

  reloc_tag_pipe #(.DEPTH(MEM_LAT)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .tag_i      (tag_w),
    .rd_valid_o (rd_ok)
  );

  assign rd_valid_o = rd_ok;
  assign rd_data_o  = rd_ok ? mem_rdata_i : '0;
endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LAT    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_valid_i,
  input logic              ref_write_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              fault_o,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o
);
  // good reads seen at the memory port, aged by the latency
  logic [LAT-1:0] good_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_rd_q <= '0;
    else        good_rd_q <= {good_rd_q[LAT-2:0], mem_req_o && !mem_we_o && !fault_o};
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!mem_req_o && !fault_o && !rd_valid_o));

  p_req_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> $past(ref_valid_i));

  p_fault_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(ref_valid_i));

  p_bad_write_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && $past(ref_write_i)) |-> !mem_req_o);

  p_bad_read_issued_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !$past(ref_write_i)) |-> (mem_req_o && !mem_we_o));

  p_rd_valid_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o == good_rd_q[LAT-1]);

  p_masked_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> (rd_data_o == '0));
endmodule

bind reloc_guard reloc_guard_chk #(.DATA_W(DATA_W), .LAT(MEM_LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_valid_i (ref_valid_i),
  .ref_write_i (ref_write_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .fault_o     (fault_o),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o)
);

// File: tb/tb_reloc_guard.sv
`timescale 1ns/1ps
module tb_reloc_guard;
  localparam int LW = 5, PW = 7, DW = 8, LAT = 4;
  localparam int PMASK = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load_i = 0, cfg_sel_i = 0;
  logic [PW-1:0] cfg_value_i = '0;
  logic ref_valid_i = 0, ref_write_i = 0;
  logic [LW-1:0] ref_laddr_i = '0;
  logic [DW-1:0] ref_wdata_i = '0;
  logic mem_req_o, mem_we_o, rd_valid_o, fault_o;
  logic [PW-1:0] mem_paddr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i, rd_data_o;

  always #2.5 clk = ~clk; // 200 MHz

  reloc_guard #(.LADDR_W(LW), .PADDR_W(PW), .DATA_W(DW), .MEM_LAT(LAT)) dut (.*);

  // memory model with fixed latency
  logic [DW-1:0] mem [128];
  logic [DW-1:0] rq [LAT];
  always @(posedge clk) begin
    if (mem_req_o && mem_we_o) mem[mem_paddr_o] <= mem_wdata_o;
    rq[0] <= (mem_req_o && !mem_we_o) ? mem[mem_paddr_o] : 8'h5A;
    for (int i = 1; i < LAT; i++) rq[i] <= rq[i-1];
  end
  assign mem_rdata_i = rq[LAT-1];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  bit chk_on = 0;
  int sb_base = 0, sb_bound = 0;
  int shadow [128];
  bit e_req[16], e_we[16], e_flt[16], e_rv[16];
  int e_pa[16], e_wd[16], e_rd[16];

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the computed schedule
  always @(negedge clk) begin
    if (chk_on) begin
      int k;
      k = cyc & 15;
      chk(mem_req_o, e_req[k], "R2 R4 R5 mem_req_o");
      if (e_req[k]) begin
        chk(mem_we_o, e_we[k], "R2 R5 mem_we_o");
        chk(mem_paddr_o, e_pa[k], "R2 mem_paddr_o");
        if (e_we[k]) chk(mem_wdata_o, e_wd[k], "R2 mem_wdata_o");
      end
      chk(fault_o, e_flt[k], "R3 fault_o");
      chk(rd_valid_o, e_rv[k], "R6 R8 R10 rd_valid_o");
      chk(rd_data_o, e_rv[k] ? e_rd[k] : 0, "R6 R7 rd_data_o");
      e_req[k] = 0; e_we[k] = 0; e_flt[k] = 0; e_rv[k] = 0;
    end
  end

  task automatic step(input bit v, input bit w, input int la, input int wd,
                      input bit ld, input bit sel, input int val);
    @(negedge clk);
    ref_valid_i = v; ref_write_i = w; ref_laddr_i = la[LW-1:0];
    ref_wdata_i = wd[DW-1:0];
    cfg_load_i = ld; cfg_sel_i = sel; cfg_value_i = val[PW-1:0];
    if (v) begin
      int k, r, pa;
      bit viol;
      k = (cyc + 1) & 15;
      r = (cyc + 1 + LAT) & 15;
      viol = (la >= sb_bound);
      pa = (sb_base + la) & PMASK;
      e_flt[k] = viol;
      if (!w || !viol) begin
        e_req[k] = 1; e_we[k] = w; e_pa[k] = pa; e_wd[k] = wd;
      end
      if (!w && !viol) begin
        e_rv[r] = 1; e_rd[r] = shadow[pa];
      end
      if (w && !viol) shadow[pa] = wd & 255;
    end
    if (ld) begin
      if (sel) sb_bound = val; else sb_base = val;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic cfg(input bit sel, input int val);
    step(0, 0, 0, 0, 1, sel, val);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i] = DW'((i * 5 + 7) & 255);
      shadow[i] = (i * 5 + 7) & 255;
    end
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    chk(mem_req_o, 0, "R1 mem_req_o in reset");
    chk(fault_o, 0, "R1 fault_o in reset");
    chk(rd_valid_o, 0, "R1 rd_valid_o in reset");
    rst_n = 1'b1;
    chk_on = 1;
    // R1: bound is zero after reset, so the first read faults but still issues
    step(1, 0, 0, 0, 0, 0, 0);
    idle(LAT + 2);

    // near-exhaustive read sweep, wrap included by base 120 (R2 R3 R5 R6 R7)
    for (int bi = 0; bi < 3; bi++) begin
      for (int di = 0; di < 5; di++) begin
        int bases[3] = '{0, 37, 120};
        int bnds[5]  = '{0, 1, 17, 31, 32};
        cfg(0, bases[bi]);
        cfg(1, bnds[di]);
        for (int la = 0; la < 32; la++) step(1, 0, la, 0, 0, 0, 0);
      end
    end
    idle(LAT + 2);

    // R4 R8: write sweep with bound 17; faulting writes must leave memory alone
    cfg(0, 37); cfg(1, 17);
    for (int la = 0; la < 32; la++) step(1, 1, la, (la * 11 + 3) & 255, 0, 0, 0);
    cfg(1, 32);
    for (int la = 0; la < 32; la++) step(1, 0, la, 0, 0, 0, 0);
    idle(LAT + 2);

    // R9: loads on the same edge as a reference use old values
    step(1, 0, 10, 0, 1, 1, 5);   // bound 32 still applies: no fault
    step(1, 0, 10, 0, 0, 0, 0);   // bound 5 now: fault
    cfg(1, 32);
    step(1, 0, 3, 0, 1, 0, 50);   // base 37 still applies
    step(1, 0, 3, 0, 0, 0, 0);    // base 50 now
    idle(LAT + 2);

    // R10: clear the bound while good reads are in flight
    step(1, 0, 1, 0, 0, 0, 0);
    step(1, 0, 2, 0, 0, 0, 0);
    step(1, 0, 3, 0, 1, 1, 0);
    step(1, 0, 4, 0, 0, 0, 0);    // faults under bound 0
    idle(LAT + 3);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule